// File: doc/BRIEF.md
# Interlocked Strobe/Acknowledge Parallel Port

This block moves bytes across a parallel pin group with a two-wire, fully interlocked handshake, one byte per four-edge cycle. A single mode input picks the direction. When it selects receive, an external sender drives a byte and pulls a low-active strobe. The port takes the byte and drops its acknowledge line. It raises that line again only after the local logic has taken the byte and the sender has released the strobe. When the mode input selects transmit, the local logic hands a byte over a valid/ready interface. The port drives the byte onto the pins and then pulls its strobe low. It holds the strobe until the far side drops acknowledge, releases it, and starts no new byte until acknowledge is high again.

Both incoming handshake wires pass through a flop-chain synchronizer before any decision uses them. A busy flag reports that a transfer is in flight. A one-cycle pulse marks each completed byte in either direction. If the mode input changes while a byte is moving, the transfer is dropped and both outgoing handshake wires return to their idle high level.

Top module: `hs_par_port`

## Requirements
- R1: While reset is asserted and after its release with no stimulus, strb_out_n and ack_out are 1 and loc_rx_valid, busy and xfer_done are 0.
- R2: In receive mode (dir_out = 0), a high-to-low change of strb_in_n made between clock edges makes ack_out go low on the third rising edge after it. At that same edge, loc_rx_valid rises, loc_rx_data takes the value on pad_data_in, and xfer_done is high for exactly one cycle.
- R3: In receive mode, pad_data_in may change once ack_out is low without altering the byte presented on loc_rx_data.
- R4: In receive mode, ack_out stays low, and loc_rx_valid with loc_rx_data stay unchanged, until the byte is consumed (loc_rx_valid and loc_rx_ready both 1 at an edge) and strb_in_n is back high. ack_out then returns high within four cycles.
- R5: In transmit mode (dir_out = 1), loc_tx_ready is 1 only while the port is idle and ack_in is high. On an accepting edge, pad_data_out takes loc_tx_data and busy rises, while strb_out_n stays high. strb_out_n falls one edge later and pad_data_out holds while it is low.
- R6: In transmit mode, strb_out_n stays low while ack_in is high. After ack_in falls between edges, strb_out_n returns high on the third rising edge, with a one-cycle xfer_done pulse at that edge.
- R7: In transmit mode, while ack_in is still low after a completed byte, loc_tx_ready stays 0, strb_out_n stays high and pad_data_out keeps the previous byte. The next byte starts only after ack_in has returned high.
- R8: A change of dir_out aborts any transfer. After the next rising edge, strb_out_n and ack_out are 1 and loc_rx_valid and busy are 0. In receive mode strb_out_n stays 1, and in transmit mode ack_out stays 1.
- R9: With the default configuration, pad_data_oe is 0 in receive mode and 1 in transmit mode.
- R10: busy is 1 from the byte being latched or accepted until the handshake has returned to idle. While busy is 0, both strb_out_n and ack_out are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, low active |
| dir_out | input | 1 | Direction: 0 receive, 1 transmit |
| pad_data_in | input | DATA_W | Byte sampled from the pins in receive mode |
| pad_data_out | output | DATA_W | Byte driven onto the pins in transmit mode |
| pad_data_oe | output | 1 | Output enable for the data pins |
| strb_in_n | input | 1 | Incoming strobe from the sender, low active |
| strb_out_n | output | 1 | Outgoing strobe to the receiver, low active |
| ack_in | input | 1 | Incoming acknowledge from the receiver, high when ready |
| ack_out | output | 1 | Outgoing acknowledge to the sender, high when ready |
| loc_rx_data | output | DATA_W | Received byte to the local side |
| loc_rx_valid | output | 1 | Received byte is waiting |
| loc_rx_ready | input | 1 | Local side takes the received byte |
| loc_tx_data | input | DATA_W | Byte from the local side to transmit |
| loc_tx_valid | input | 1 | Local side offers a byte |
| loc_tx_ready | output | 1 | Port accepts the offered byte |
| busy | output | 1 | A transfer is in progress |
| xfer_done | output | 1 | One-cycle pulse per completed byte |

## Verification
The checker takes as given that the far side honours the interlock. A sender changes pad_data_in only after ack_out is low and strobes again only after ack_out is back high. A receiver drops ack_in only while strb_out_n is low. The stimulus tasks wait on the port's own handshake outputs before each edge they make, so every sequence stays inside that protocol. Direction changes are made only in the abort scenario and after the reset settling cycles. Inputs move between clock edges, which keeps the synchronizer latency a fixed count of edges.

// File: rtl/hs_par_pkg.sv
package hs_par_pkg;
   typedef enum logic [0:0] {
      RX_IDLE = 1'b0,
      RX_HOLD = 1'b1
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_SETUP   = 2'd1,
      TX_STROBE  = 2'd2,
      TX_RECOVER = 2'd3
   } tx_state_e;
endpackage

// File: rtl/hs_par_sync.sv
module hs_par_sync #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= INIT;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= INIT;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_par_rx.sv
module hs_par_rx
   import hs_par_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              strb_lvl,
   input  logic              strb_fall,
   input  logic [DATA_W-1:0] pad_data,
   input  logic              loc_ready,
   output logic [DATA_W-1:0] loc_data,
   output logic              loc_valid,
   output logic              ack,
   output logic              busy,
   output logic              done
);
   rx_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         loc_valid <= 1'b0;
         loc_data  <= '0;
         done      <= 1'b0;
      end else if (!enable) begin
         state     <= RX_IDLE;
         loc_valid <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (strb_fall) begin
                  loc_data  <= pad_data;
                  loc_valid <= 1'b1;
                  done      <= 1'b1;
                  state     <= RX_HOLD;
               end
            end
            RX_HOLD: begin
               if (loc_valid && loc_ready) loc_valid <= 1'b0;
               if (!loc_valid && strb_lvl) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign ack  = (state == RX_IDLE);
   assign busy = (state != RX_IDLE);
endmodule

// File: rtl/hs_par_tx.sv
module hs_par_tx
   import hs_par_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ack_lvl,
   input  logic [DATA_W-1:0] loc_data,
   input  logic              loc_valid,
   output logic              loc_ready,
   output logic [DATA_W-1:0] pad_data,
   output logic              strb_n,
   output logic              busy,
   output logic              done
);
   tx_state_e state;

   assign loc_ready = enable && (state == TX_IDLE) && ack_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TX_IDLE;
         pad_data <= '0;
         done     <= 1'b0;
      end else if (!enable) begin
         state <= TX_IDLE;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (loc_valid && loc_ready) begin
                  pad_data <= loc_data;
                  state    <= TX_SETUP;
               end
            end
            TX_SETUP:  state <= TX_STROBE;
            TX_STROBE: begin
               if (!ack_lvl) begin
                  done  <= 1'b1;
                  state <= TX_RECOVER;
               end
            end
            TX_RECOVER: begin
               if (ack_lvl) state <= TX_IDLE;
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign strb_n = (state != TX_STROBE);
   assign busy   = (state != TX_IDLE);
endmodule

// File: rtl/hs_par_port.sv
module hs_par_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit DRIVE_IDLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_out,
   input  logic [DATA_W-1:0] pad_data_in,
   output logic [DATA_W-1:0] pad_data_out,
   output logic              pad_data_oe,
   input  logic              strb_in_n,
   output logic              strb_out_n,
   input  logic              ack_in,
   output logic              ack_out,
   output logic [DATA_W-1:0] loc_rx_data,
   output logic              loc_rx_valid,
   input  logic              loc_rx_ready,
   input  logic [DATA_W-1:0] loc_tx_data,
   input  logic              loc_tx_valid,
   output logic              loc_tx_ready,
   output logic              busy,
   output logic              xfer_done
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_par_port: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hs_par_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic strb_s, ack_s, strb_prev, strb_fall;
   logic rx_busy, tx_busy, rx_done, tx_done;

   hs_par_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d(strb_in_n), .q(strb_s)
   );
   hs_par_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_prev <= 1'b1;
      else        strb_prev <= strb_s;
   end
   assign strb_fall = strb_prev & ~strb_s;

   hs_par_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .enable(~dir_out),
      .strb_lvl(strb_s), .strb_fall(strb_fall), .pad_data(pad_data_in),
      .loc_ready(loc_rx_ready), .loc_data(loc_rx_data), .loc_valid(loc_rx_valid),
      .ack(ack_out), .busy(rx_busy), .done(rx_done)
   );

   hs_par_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .enable(dir_out), .ack_lvl(ack_s),
      .loc_data(loc_tx_data), .loc_valid(loc_tx_valid), .loc_ready(loc_tx_ready),
      .pad_data(pad_data_out), .strb_n(strb_out_n), .busy(tx_busy), .done(tx_done)
   );

   generate
      if (DRIVE_IDLE) begin : g_oe_mode
         assign pad_data_oe = dir_out;
      end else begin : g_oe_xfer
         assign pad_data_oe = dir_out & tx_busy;
      end
   endgenerate

   assign busy      = rx_busy | tx_busy;
   assign xfer_done = rx_done | tx_done;
endmodule

// File: rtl/hs_par_port_chk.sv
module hs_par_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_out,
   input logic [DATA_W-1:0] pad_data_out,
   input logic              strb_out_n,
   input logic              ack_out,
   input logic [DATA_W-1:0] loc_rx_data,
   input logic              loc_rx_valid,
   input logic              loc_rx_ready,
   input logic              busy,
   input logic              xfer_done
);
   logic armed, dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         armed <= 1'b1;
         dir_q <= dir_out;
      end
   end

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   assert_valid_blocks_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rx_valid |-> !ack_out);

   assert_rx_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && loc_rx_valid && !loc_rx_ready && !dir_out)
      |=> (dir_out || (loc_rx_valid && $stable(loc_rx_data))));

   assert_tx_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !strb_out_n) |-> $stable(pad_data_out));

   assert_strobe_release_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && dir_out && dir_q && $rose(strb_out_n)) |-> xfer_done);

   assert_no_strobe_in_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !dir_out && !dir_q) |-> strb_out_n);

   assert_no_ack_in_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && dir_out && dir_q) |-> ack_out);

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (strb_out_n && ack_out));
endmodule

bind hs_par_port hs_par_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .pad_data_out(pad_data_out),
   .strb_out_n(strb_out_n), .ack_out(ack_out), .loc_rx_data(loc_rx_data),
   .loc_rx_valid(loc_rx_valid), .loc_rx_ready(loc_rx_ready), .busy(busy),
   .xfer_done(xfer_done)
);

// File: tb/hs_par_port_tb.sv
module hs_par_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir_out = 1'b0;
   logic [7:0] pad_data_in = 8'h00;
   logic [7:0] pad_data_out;
   logic       pad_data_oe;
   logic       strb_in_n = 1'b1;
   logic       strb_out_n;
   logic       ack_in = 1'b1;
   logic       ack_out;
   logic [7:0] loc_rx_data;
   logic       loc_rx_valid;
   logic       loc_rx_ready = 1'b0;
   logic [7:0] loc_tx_data = 8'h00;
   logic       loc_tx_valid = 1'b0;
   logic       loc_tx_ready;
   logic       busy;
   logic       xfer_done;

   int n_checks = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hs_par_port u_dut (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
      .pad_data_in(pad_data_in), .pad_data_out(pad_data_out), .pad_data_oe(pad_data_oe),
      .strb_in_n(strb_in_n), .strb_out_n(strb_out_n),
      .ack_in(ack_in), .ack_out(ack_out),
      .loc_rx_data(loc_rx_data), .loc_rx_valid(loc_rx_valid), .loc_rx_ready(loc_rx_ready),
      .loc_tx_data(loc_tx_data), .loc_tx_valid(loc_tx_valid), .loc_tx_ready(loc_tx_ready),
      .busy(busy), .xfer_done(xfer_done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Poll ack_out until it reaches lvl; returns cycles waited.
   task automatic wait_ack_out(input logic lvl, input int limit, output int waited);
      waited = 0;
      while (ack_out !== lvl && waited < limit) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic t_reset;
      check("R1 strb_out_n in reset", strb_out_n, 1);
      check("R1 ack_out in reset", ack_out, 1);
      check("R1 loc_rx_valid in reset", loc_rx_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(3);
      check("R1 strb_out_n after reset", strb_out_n, 1);
      check("R1 ack_out after reset", ack_out, 1);
      check("R1 busy after reset", busy, 0);
      check("R1 xfer_done after reset", xfer_done, 0);
      check("R9 oe low in receive mode", pad_data_oe, 0);
   endtask

   // Sender side of one byte up to ack_out falling, with timing checks.
   task automatic rx_strobe(input logic [7:0] b);
      @(negedge clk);
      pad_data_in = b;
      strb_in_n   = 1'b0;
      @(negedge clk);
      check("R2 ack_out high after edge 1", ack_out, 1);
      @(negedge clk);
      check("R2 ack_out high after edge 2", ack_out, 1);
      @(negedge clk);
      check("R2 ack_out low after edge 3", ack_out, 0);
      check("R2 loc_rx_valid", loc_rx_valid, 1);
      check("R2 loc_rx_data", loc_rx_data, b);
      check("R2 xfer_done pulse", xfer_done, 1);
      check("R10 busy while holding", busy, 1);
   endtask

   task automatic t_rx_basic;
      int w;
      rx_strobe(8'hA5);
      pad_data_in = 8'h3C;
      @(negedge clk);
      check("R2 xfer_done one cycle", xfer_done, 0);
      check("R3 byte kept after pad change", loc_rx_data, 8'hA5);
      strb_in_n    = 1'b1;
      loc_rx_ready = 1'b1;
      @(negedge clk);
      loc_rx_ready = 1'b0;
      check("R4 valid cleared on consume", loc_rx_valid, 0);
      wait_ack_out(1'b1, 8, w);
      check("R4 ack_out returns high", ack_out, 1);
      check("R4 ack_out return latency", (w <= 4) ? 1 : 0, 1);
      check("R10 busy low at idle", busy, 0);
   endtask

   task automatic t_rx_backpressure;
      int w;
      idle(2);
      rx_strobe(8'h5E);
      @(negedge clk);
      strb_in_n = 1'b1;
      idle(8);
      check("R4 ack_out low without consume", ack_out, 0);
      check("R4 valid held without consume", loc_rx_valid, 1);
      check("R4 data held without consume", loc_rx_data, 8'h5E);
      loc_rx_ready = 1'b1;
      @(negedge clk);
      loc_rx_ready = 1'b0;
      wait_ack_out(1'b1, 8, w);
      check("R4 ack_out high after late consume", ack_out, 1);
      idle(2);
      // Byte consumed while the strobe is still held low.
      rx_strobe(8'h81);
      loc_rx_ready = 1'b1;
      @(negedge clk);
      loc_rx_ready = 1'b0;
      idle(6);
      check("R4 ack_out low while strobe held", ack_out, 0);
      strb_in_n = 1'b1;
      wait_ack_out(1'b1, 8, w);
      check("R4 ack_out high after strobe release", ack_out, 1);
      idle(2);
   endtask

   task automatic tx_offer(input logic [7:0] b, input int limit, output bit ok);
      ok = 1'b0;
      @(negedge clk);
      loc_tx_data  = b;
      loc_tx_valid = 1'b1;
      for (int i = 0; i < limit; i++) begin
         if (loc_tx_ready) begin
            ok = 1'b1;
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      loc_tx_valid = 1'b0;
   endtask

   task automatic t_tx_basic;
      bit ok;
      @(negedge clk);
      dir_out = 1'b1;
      idle(3);
      check("R9 oe high in transmit mode", pad_data_oe, 1);
      check("R5 ready when idle and ack high", loc_tx_ready, 1);
      tx_offer(8'h5A, 4, ok);
      check("R5 byte accepted", ok, 1);
      check("R5 data driven at accept", pad_data_out, 8'h5A);
      check("R5 strobe still high at accept", strb_out_n, 1);
      check("R5 ready low after accept", loc_tx_ready, 0);
      check("R10 busy after accept", busy, 1);
      @(negedge clk);
      check("R5 strobe low one edge later", strb_out_n, 0);
      idle(5);
      check("R6 strobe held while ack high", strb_out_n, 0);
      ack_in = 1'b0;
      @(negedge clk);
      check("R6 strobe low after edge 1", strb_out_n, 0);
      @(negedge clk);
      check("R6 strobe low after edge 2", strb_out_n, 0);
      @(negedge clk);
      check("R6 strobe high after edge 3", strb_out_n, 1);
      check("R6 xfer_done pulse", xfer_done, 1);
      @(negedge clk);
      check("R6 xfer_done one cycle", xfer_done, 0);
   endtask

   task automatic t_tx_wait_ack;
      int w;
      loc_tx_data  = 8'hC3;
      loc_tx_valid = 1'b1;
      idle(5);
      check("R7 no ready while ack low", loc_tx_ready, 0);
      check("R7 strobe high while ack low", strb_out_n, 1);
      check("R7 previous byte kept", pad_data_out, 8'h5A);
      ack_in = 1'b1;
      w = 0;
      while (strb_out_n !== 1'b0 && w < 12) begin
         if (loc_tx_ready) begin
            @(negedge clk);
            loc_tx_valid = 1'b0;
         end else begin
            @(negedge clk);
         end
         w++;
      end
      loc_tx_valid = 1'b0;
      check("R7 next strobe after ack high", strb_out_n, 0);
      check("R7 next byte on pins", pad_data_out, 8'hC3);
      ack_in = 1'b0;
      idle(4);
      check("R6 second strobe released", strb_out_n, 1);
      ack_in = 1'b1;
      idle(4);
      check("R10 busy low after recovery", busy, 0);
   endtask

   task automatic t_abort;
      bit ok;
      // Abort a transmit in the strobe phase.
      tx_offer(8'h11, 4, ok);
      @(negedge clk);
      check("R8 strobe low before abort", strb_out_n, 0);
      dir_out = 1'b0;
      @(negedge clk);
      check("R8 strobe idle after abort", strb_out_n, 1);
      check("R8 busy low after tx abort", busy, 0);
      check("R9 oe low after switch", pad_data_oe, 0);
      idle(3);
      // Abort a receive holding a byte.
      rx_strobe(8'h77);
      dir_out = 1'b1;
      @(negedge clk);
      check("R8 ack_out idle after abort", ack_out, 1);
      check("R8 valid dropped after abort", loc_rx_valid, 0);
      check("R8 busy low after rx abort", busy, 0);
      idle(3);
      check("R8 ack_out stays high in transmit", ack_out, 1);
      strb_in_n = 1'b1;
      @(negedge clk);
      dir_out = 1'b0;
      idle(3);
      check("R8 strobe stays high in receive", strb_out_n, 1);
   endtask

   initial begin
      t_reset();
      t_rx_basic();
      t_rx_backpressure();
      t_tx_basic();
      t_tx_wait_ack();
      t_abort();
      idle(2);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule